// File: doc/BRIEF.md
# Alternating-Channel Serial ADC Sequencer

This block is a serial-peripheral master for a two-input, 10-bit successive-approximation converter. Once enabled, it runs conversion frames back to back. Each frame asks for a single-ended conversion, and the requested input alternates between input 0 and input 1 on every frame. No host action is needed to switch between the two inputs.

The serial clock comes from the system clock by integer division. A 24 MHz system clock with the default divide ratio of 20 gives a 1.2 MHz serial clock. In each frame the block drives chip select, the serial clock and the command line. It shifts the returned sample in, most significant bit first. When the frame closes, it presents the sample on a parallel bus together with the input it came from, and raises a valid strobe for one system clock cycle.

Top module: `dual_adc_sequencer`

## Requirements
- R1: A synchronous active-high reset drives chip select high, the serial clock low and the valid strobe low. The first frame after reset converts input 0, even when the reset arrives in the middle of a frame.
- R2: The serial clock period is DIV_RATIO system clocks, split into DIV_RATIO/2 clocks low and DIV_RATIO/2 clocks high. It idles low, and each frame holds exactly 16 rising edges.
- R3: The converter samples the command line on the first four rising edges of a frame, and the bits seen there are 1, 1, the input number, 1. These are the start bit, the single-ended mode bit, the input select and the MSB-first request. The command line changes only while the serial clock is low, and it is 0 after the command.
- R4: The input tag on completed frames reads 0, 1, 0, 1 and so on, with no host involvement.
- R5: The sample is taken from the data line on rising edges 6 through 15 of the frame, the first of these being the most significant bit. Rising edges 1 through 5 and rising edge 16 do not contribute to the sample.
- R6: Chip select falls at least DIV_RATIO/2 system clocks before the first rising serial clock edge. Between two frames it stays high for at least DIV_RATIO system clocks.
- R7: The valid strobe is high for exactly one system clock cycle per frame. It rises in the cycle in which chip select returns high, and it comes with the sample and the input tag of that frame.
- R8: A frame starts only while enable is high. A frame that is already running finishes normally after enable falls, and no further frame follows it.
- R9: The serial clock toggles only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new conversion frames to start |
| adcCsN | output | 1 | Chip select to the converter, active low |
| adcSclk | output | 1 | Serial clock to the converter |
| adcMosi | output | 1 | Command data to the converter |
| adcMiso | input | 1 | Sample data from the converter |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |
| sampleChan | output | 1 | Input number of the presented sample |
| sampleData | output | SAMPLE_W | Captured sample, right-aligned |

## Verification
The converter model builds the sample it returns from the input-select bit it decodes in the command. A design that sends the wrong select bit, or puts it on the wrong clock edge, therefore returns the other input's data and a mismatched tag. Boundary patterns put ones or zeros at both ends of the word. An off-by-one in the sampling window then shows up as a shifted or truncated value, and so does capturing the null bit or the trailing bit. The bench measures the chip-select lead time, the inter-frame gap and every serial clock period, which catches a wrong prescaler or a missing guard interval. It also drops enable both between frames and in the middle of a frame, and applies reset in the middle of a frame. A design that ignores enable, cuts a frame short, or resumes on input 1 after reset then fails.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Per-cycle events that the sequencing control hands to the datapath.
  typedef struct packed {
    logic frameStart;   // chip select is being lowered; present first command bit
    logic fallEdge;     // serial clock falls this cycle; advance the command line
    logic sampleIn;     // serial clock rises inside the sample window; shift in
    logic commit;       // frame ends; publish the sample and swap input
  } seqStrobes_t;

  localparam int CMD_BITS = 4;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_RATIO    = 20,
  parameter int FRAME_CLKS   = 16,
  parameter int FIRST_SAMPLE = 5,
  parameter int SAMPLE_W     = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  output logic        csN,
  output logic        sclk,
  output seqStrobes_t stb
);

  localparam int HALF = DIV_RATIO / 2;
  localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int HW   = $clog2(2 * FRAME_CLKS);
  localparam int CW   = HW - 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(HALF - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(2 * FRAME_CLKS - 1);
  localparam logic [CW-1:0] FIRST_IDX = CW'(FIRST_SAMPLE);
  localparam logic [CW-1:0] LAST_IDX  = CW'(FIRST_SAMPLE + SAMPLE_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} seqState_t;

  seqState_t       state;
  logic [PW-1:0]   preCnt;
  logic [HW-1:0]   halfCnt;
  logic            tick;
  logic            riseNow;
  logic [CW-1:0]   clkIdx;

  assign tick   = (preCnt == PRE_LAST);
  assign clkIdx = halfCnt[HW-1:1];

  always_comb begin
    riseNow        = (state == S_FRAME) && tick && !halfCnt[0];
    stb.frameStart = (state == S_IDLE) && enable;
    stb.fallEdge   = (state == S_FRAME) && tick && halfCnt[0];
    stb.sampleIn   = riseNow && (clkIdx >= FIRST_IDX) && (clkIdx <= LAST_IDX);
    stb.commit     = stb.fallEdge && (halfCnt == HALF_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      csN     <= 1'b1;
      sclk    <= 1'b0;
      preCnt  <= '0;
      halfCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          preCnt  <= '0;
          halfCnt <= '0;
          if (enable) begin
            state <= S_FRAME;
            csN   <= 1'b0;
          end
        end
        S_FRAME: begin
          preCnt <= tick ? '0 : preCnt + 1'b1;
          if (tick) begin
            sclk <= !halfCnt[0];
            if (halfCnt == HALF_LAST) begin
              csN     <= 1'b1;
              state   <= S_GAP;
              halfCnt <= '0;
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end
        end
        S_GAP: begin
          preCnt <= tick ? '0 : preCnt + 1'b1;
          if (tick) begin
            if (halfCnt[0]) begin
              state   <= S_IDLE;
              halfCnt <= '0;
            end else begin
              halfCnt <= halfCnt + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobes_t         stb,
  input  logic                miso,
  output logic                mosi,
  output logic                valid,
  output logic                chanOut,
  output logic [SAMPLE_W-1:0] dataOut
);

  logic                nextChan;
  logic [2:0]          cmdPos;     // index of the command bit now on the line
  logic [SAMPLE_W-1:0] shiftReg;
  logic [CMD_BITS-1:0] cmdWord;
  logic [CMD_BITS-1:0] cmdAhead;

  // start, single-ended, input select, MSB-first request; sent from bit 3 down
  assign cmdWord  = {1'b1, 1'b1, nextChan, 1'b1};
  assign cmdAhead = cmdWord << (cmdPos + 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      nextChan <= 1'b0;
      cmdPos   <= '0;
      shiftReg <= '0;
      mosi     <= 1'b0;
      valid    <= 1'b0;
      chanOut  <= 1'b0;
      dataOut  <= '0;
    end else begin
      valid <= stb.commit;
      if (stb.frameStart) begin
        mosi   <= cmdWord[CMD_BITS-1];
        cmdPos <= '0;
      end
      if (stb.fallEdge) begin
        mosi <= cmdAhead[CMD_BITS-1];
        if (cmdPos != 3'(CMD_BITS)) cmdPos <= cmdPos + 1'b1;
      end
      if (stb.sampleIn) shiftReg <= {shiftReg[SAMPLE_W-2:0], miso};
      if (stb.commit) begin
        dataOut  <= shiftReg;
        chanOut  <= nextChan;
        nextChan <= !nextChan;
        mosi     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dual_adc_sequencer.sv
module dual_adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DIV_RATIO    = 20,
  parameter int SAMPLE_W     = 10,
  parameter int FRAME_CLKS   = 16,
  parameter int FIRST_SAMPLE = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  output logic                adcCsN,
  output logic                adcSclk,
  output logic                adcMosi,
  input  logic                adcMiso,
  output logic                sampleValid,
  output logic                sampleChan,
  output logic [SAMPLE_W-1:0] sampleData
);

  seqStrobes_t stb;

  adc_seq_ctrl #(
    .DIV_RATIO   (DIV_RATIO),
    .FRAME_CLKS  (FRAME_CLKS),
    .FIRST_SAMPLE(FIRST_SAMPLE),
    .SAMPLE_W    (SAMPLE_W)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .csN   (adcCsN),
    .sclk  (adcSclk),
    .stb   (stb)
  );

  adc_seq_dpath #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .miso   (adcMiso),
    .mosi   (adcMosi),
    .valid  (sampleValid),
    .chanOut(sampleChan),
    .dataOut(sampleData)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic adcCsN,
  input logic adcSclk,
  input logic adcMosi,
  input logic sampleValid,
  input logic sampleChan
);

  logic lastChan;
  logic seenSample;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastChan   <= 1'b0;
      seenSample <= 1'b0;
    end else if (sampleValid) begin
      lastChan   <= sampleChan;
      seenSample <= 1'b1;
    end
  end

  AST_SCLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    adcCsN |-> !adcSclk); // R9

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid); // R7

  AST_VALID_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> adcCsN); // R7

  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(adcSclk) |-> $stable(adcMosi)); // R3

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(adcCsN) |-> $past(enable)); // R8

  AST_RISE_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(adcSclk) |-> $past(!adcCsN)); // R6

  AST_CHAN_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && seenSample) |-> (sampleChan != lastChan)); // R4

endmodule

bind dual_adc_sequencer adc_seq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .adcCsN     (adcCsN),
  .adcSclk    (adcSclk),
  .adcMosi    (adcMosi),
  .sampleValid(sampleValid),
  .sampleChan (sampleChan)
);

// File: tb/dual_adc_sequencer_tb.sv
module dual_adc_sequencer_tb;

  localparam int DIV  = 20;
  localparam int HALF = DIV / 2;
  localparam int NV   = 8;

  // bit 10: expected input tag; bits 9:0: base pattern (inverted by model for input 1)
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 10'h2A5}, {1'b1, 10'h0F0}, {1'b0, 10'h000}, {1'b1, 10'h3FF},
    {1'b0, 10'h200}, {1'b1, 10'h001}, {1'b0, 10'h155}, {1'b1, 10'h37C}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, enable, adcMiso;
  logic       adcCsN, adcSclk, adcMosi, sampleValid, sampleChan;
  logic [9:0] sampleData;

  dual_adc_sequencer u_dut (
    .clk(clk), .rst(rst), .enable(enable),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .adcMosi(adcMosi), .adcMiso(adcMiso),
    .sampleValid(sampleValid), .sampleChan(sampleChan), .sampleData(sampleData)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // ---------------- converter model ----------------
  bit         modelOn = 0;
  int         riseCnt = 0;
  int         lastRises = 0;
  int         frameNum = 0;
  logic [3:0] cmdBits = '0;
  logic       mdlChan = 1'b0;
  logic [9:0] mdlWord = '0;

  always @(negedge adcCsN) if (modelOn) begin
    riseCnt = 0;
    cmdBits = '0;
    adcMiso = 1'b0;
  end

  always @(posedge adcSclk) if (modelOn) begin
    if (riseCnt < 4) cmdBits = {cmdBits[2:0], adcMosi};
    if (riseCnt == 2) begin
      mdlChan = adcMosi;
      mdlWord = adcMosi ? ~VEC[frameNum % NV][9:0] : VEC[frameNum % NV][9:0];
    end
    riseCnt++;
  end

  always @(negedge adcSclk) if (modelOn && adcCsN == 1'b0) begin
    if (riseCnt >= 5 && riseCnt <= 14) adcMiso = mdlWord[14 - riseCnt];
    else adcMiso = 1'b0;
  end

  always @(posedge adcCsN) if (modelOn) begin
    lastRises = riseCnt;
    frameNum++;
  end

  // ---------------- timing monitor ----------------
  int  fallCnt = 0, gapBad = 0, leadBad = 0, periodBad = 0, idleClkBad = 0;
  int  highRun = 0, leadRun = 0, periodRun = 0;
  bit  prevCs = 1, prevSclk = 0, gotRise = 0, firstFrame = 1;

  always @(negedge clk) begin
    if (rst) begin
      prevCs = 1; prevSclk = 0; gotRise = 0; firstFrame = 1; highRun = 0;
    end else if (modelOn) begin
      if (prevCs && !adcCsN) begin
        fallCnt++;
        if (!firstFrame && highRun < DIV) gapBad++;
        firstFrame = 0; leadRun = 0; gotRise = 0;
      end
      periodRun++;
      if (!adcCsN && adcSclk && !prevSclk) begin
        if (!gotRise) begin
          if (leadRun < HALF) leadBad++;
        end else if (periodRun != DIV) periodBad++;
        gotRise = 1; periodRun = 0;
      end else if (!adcCsN && !gotRise) leadRun++;
      if (adcCsN && adcSclk) idleClkBad++;
      highRun = adcCsN ? highRun + 1 : 0;
      prevCs = adcCsN; prevSclk = adcSclk;
    end
  end

  task automatic waitValid(output bit ok);
    ok = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (sampleValid) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    bit ok;
    int f0;
    logic       expChan;
    logic [9:0] expData;
    rst = 1; enable = 0; adcMiso = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(adcCsN == 1'b1, "R1 reset csN", adcCsN, 1);
    chk(adcSclk == 1'b0, "R1 reset sclk", adcSclk, 0);
    chk(sampleValid == 1'b0, "R1 reset valid", sampleValid, 0);
    frameNum = 0; modelOn = 1; rst = 0;
    enable = 1;

    // table walk: alternating inputs, command bits, captured words
    for (int i = 0; i < NV; i++) begin
      waitValid(ok);
      chk(ok, "R7 valid seen", ok, 1);
      expChan = VEC[i][10];
      expData = expChan ? ~VEC[i][9:0] : VEC[i][9:0];
      chk(sampleChan == expChan, "R4 input tag", sampleChan, expChan);
      chk(sampleData == expData, "R5 sample word", sampleData, expData);
      chk(cmdBits == {2'b11, expChan, 1'b1}, "R3 command bits", cmdBits, {2'b11, expChan, 1'b1});
      chk(lastRises == 16, "R2 rises per frame", lastRises, 16);
      chk(adcCsN == 1'b1, "R7 valid at frame end", adcCsN, 1);
      @(negedge clk);
      chk(sampleValid == 1'b0, "R7 valid one cycle", sampleValid, 0);
      if (i == NV - 1) enable = 0;
    end
    chk(leadBad == 0, "R6 select lead", leadBad, 0);
    chk(gapBad == 0, "R6 inter-frame gap", gapBad, 0);
    chk(periodBad == 0, "R2 sclk period", periodBad, 0);
    chk(idleClkBad == 0, "R9 sclk idle", idleClkBad, 0);

    // R8: no frame while disabled
    f0 = fallCnt;
    repeat (1500) @(negedge clk);
    chk(fallCnt == f0, "R8 idle when disabled", fallCnt - f0, 0);
    chk(adcCsN == 1'b1, "R8 csN idle", adcCsN, 1);

    // R8: enable dropped mid-frame, frame still completes
    enable = 1;
    for (int n = 0; n < 200 && adcCsN; n++) @(negedge clk);
    repeat (50) @(negedge clk);
    enable = 0;
    waitValid(ok);
    chk(ok, "R8 frame completes", ok, 1);
    chk(sampleChan == 1'b0, "R4 tag after pause", sampleChan, 0);
    chk(sampleData == mdlWord, "R5 word after pause", sampleData, mdlWord);
    f0 = fallCnt;
    repeat (1500) @(negedge clk);
    chk(fallCnt == f0, "R8 no frame after drop", fallCnt - f0, 0);

    // R1: reset in the middle of an input-1 frame
    enable = 1;
    for (int n = 0; n < 200 && adcCsN; n++) @(negedge clk);
    repeat (100) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(adcCsN == 1'b1, "R1 mid-frame reset csN", adcCsN, 1);
    chk(adcSclk == 1'b0, "R1 mid-frame reset sclk", adcSclk, 0);
    chk(sampleValid == 1'b0, "R1 mid-frame reset valid", sampleValid, 0);
    @(negedge clk);
    rst = 0;
    waitValid(ok);
    chk(ok, "R1 frame after reset", ok, 1);
    chk(sampleChan == 1'b0, "R1 input 0 after reset", sampleChan, 0);
    chk(cmdBits == 4'b1101, "R3 command after reset", cmdBits, 4'b1101);
    chk(sampleData == mdlWord, "R5 word after reset", sampleData, mdlWord);
    chk(idleClkBad == 0, "R9 sclk idle", idleClkBad, 0);
    chk(periodBad == 0, "R2 sclk period", periodBad, 0);
    enable = 0;
    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule